// File: doc/BRIEF.md
# Supply Supervisor with Window Watchdog

This block is a clocked digital supervisor. It holds an active-low system reset while a digitized undervoltage flag is set or a manual reset input is low. Once both causes clear, it keeps reset low for a fixed number of cycles before it releases it. While reset is released and the watchdog is enabled, the block watches a kick input. Each falling edge of the kick must land inside a time window. An edge that comes too early is a fault, and so is a missing edge. On a fault the block pulses an active-low fault output for the same fixed hold time.

Both outputs model open-drain pins. Each has an output enable that is high exactly when the pin pulls low. While the enable is low the pin floats. While reset is low, the fault output is never driven.

A two-bit select code chooses the window bounds. The bounds come either from two programmable inputs or from one of two preset pairs, which are set by parameters.

Top module: `supv_wdt`

## Requirements
- R1: In the cycle after the synchronous reset `rst` is applied, the outputs are `rst_n_o`=0, `rst_oe`=1, `wdf_n_o`=1 and `wdf_oe`=0.
- R2: If `uv_flag`=1 or `mr_n`=0 at a rising clock edge, then `rst_n_o` is 0 after that edge.
- R3: After the last edge at which `uv_flag`=1 or `mr_n`=0, `rst_n_o` returns to 1 at exactly the TRST-th following edge, provided both causes stay clear.
- R4: The kick input passes through two synchronizer flops and then an edge register. A falling edge of `kick` ahead of edge E0 is acted on at edge E2.
- R5: The window counter c counts watchdog-active cycles since the window started. If a kick edge is acted on while c < lower bound, the cycle is a fault.
- R6: If no kick edge is acted on by the time c reaches upper bound − 1, the cycle is a fault. An edge acted on at c with lower ≤ c ≤ upper−1 is valid.
- R7: A valid kick edge raises no fault and restarts the window at c = 0.
- R8: A fault drives `wdf_n_o` low for exactly TRST cycles. The output is then released and the window restarts from c = 0.
- R9: While `rst_n_o` is 0, `wdf_n_o`=1 and `wdf_oe`=0. A reset cause that appears during a fault pulse ends the pulse at the next edge.
- R10: While `wd_en`=0, kicks are ignored, no fault is raised and the window is held at c = 0. Kicks are also ignored while either output is low.
- R11: `tsel` encoding: 00 uses (`prog_lo`, `prog_hi`), 01 uses (A_LO, A_HI), and 10 or 11 uses (B_LO, B_HI).
- R12: Each output enable is 1 exactly when its active-low output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| uv_flag | input | 1 | Digitized undervoltage indication |
| mr_n | input | 1 | Active-low manual reset request |
| wd_en | input | 1 | Watchdog enable, low disables it |
| kick | input | 1 | Asynchronous watchdog kick, falling edges count |
| tsel | input | 2 | Window bound select code |
| prog_lo | input | 16 | Programmable lower window bound |
| prog_hi | input | 16 | Programmable upper window bound |
| rst_n_o | output | 1 | Active-low system reset |
| rst_oe | output | 1 | Output enable for rst_n_o (pull-down active) |
| wdf_n_o | output | 1 | Active-low watchdog fault |
| wdf_oe | output | 1 | Output enable for wdf_n_o (pull-down active) |

## Verification
The assertions assume that the selected bounds satisfy 1 ≤ lower < upper. They also assume that kick edges are separated by more than the synchronizer latency. The stimulus sets the programmable pair to 6 and 15 and keeps every kick pulse low for two cycles or more. The bench changes the select code only between kick bursts. A behavioural model predicts all four outputs every cycle, and directed waits measure the hold lengths and the early, late and suppressed fault cases.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int WD_CW = 16;

    typedef logic [WD_CW-1:0] wcount_t;

    typedef struct packed {
        wcount_t lo;
        wcount_t hi;
    } window_t;

    typedef enum logic [1:0] {
        SEL_PROG     = 2'b00,
        SEL_PRESET_A = 2'b01,
        SEL_PRESET_B = 2'b10,
        SEL_SPARE    = 2'b11
    } tsel_e;

    function automatic window_t pick_window(tsel_e sel, window_t prog,
                                            window_t pa, window_t pb);
        window_t w;
        case (sel)
            SEL_PROG:     w = prog;
            SEL_PRESET_A: w = pa;
            default:      w = pb;
        endcase
        return w;
    endfunction
endpackage

// File: rtl/wdt_kick_sync.sv
module wdt_kick_sync (
    input  logic clk,
    input  logic rst,
    input  logic kick,
    output logic fall
);
    localparam int STAGES = 3;
    logic [STAGES-1:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) pipe <= '1;
        else     pipe <= {pipe[STAGES-2:0], kick};
    end

    assign fall = pipe[STAGES-1] & ~pipe[STAGES-2];
endmodule

// File: rtl/wdt_hold_timer.sv
module wdt_hold_timer #(
    parameter int   LEN     = 8,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic active
);
    localparam int HW = $clog2(LEN + 1);
    logic [HW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= RST_VAL;
            cnt    <= '0;
        end else if (clr) begin
            active <= 1'b0;
            cnt    <= '0;
        end else if (set) begin
            active <= 1'b1;
            cnt    <= '0;
        end else if (active) begin
            if (cnt == HW'(LEN - 1)) begin
                active <= 1'b0;
                cnt    <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    AST_HOLD_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt < HW'(LEN)); // R3 R8
    AST_HOLD_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !active |-> cnt == '0); // R8
endmodule

// File: rtl/wdt_window.sv
module wdt_window
    import wdt_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    active,
    input  logic    fall,
    input  window_t win,
    output logic    timeout
);
    wcount_t cnt;
    logic    early, late;

    assign early   = fall & (cnt < win.lo);
    assign late    = ~fall & (cnt >= win.hi - 1'b1);
    assign timeout = active & (early | late);

    always_ff @(posedge clk) begin
        if (rst || !active || timeout || fall) cnt <= '0;
        else                                   cnt <= cnt + 1'b1;
    end

    AST_IDLE_HOLDS_ZERO: assert property (@(posedge clk) disable iff (rst)
        !active |=> cnt == '0); // R10
    AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        (active && win.hi != '0) |-> cnt < win.hi); // R6
endmodule

// File: rtl/supv_wdt.sv
module supv_wdt
    import wdt_pkg::*;
#(
    parameter int TRST = 8,
    parameter int A_LO = 4,
    parameter int A_HI = 20,
    parameter int B_LO = 10,
    parameter int B_HI = 40
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             uv_flag,
    input  logic             mr_n,
    input  logic             wd_en,
    input  logic             kick,
    input  logic [1:0]       tsel,
    input  logic [WD_CW-1:0] prog_lo,
    input  logic [WD_CW-1:0] prog_hi,
    output logic             rst_n_o,
    output logic             rst_oe,
    output logic             wdf_n_o,
    output logic             wdf_oe
);
    localparam window_t WIN_A = '{lo: wcount_t'(A_LO), hi: wcount_t'(A_HI)};
    localparam window_t WIN_B = '{lo: wcount_t'(B_LO), hi: wcount_t'(B_HI)};

    logic    cause, rst_low, wdf_low, wd_active, fall, timeout;
    window_t win;

    assign cause     = uv_flag | ~mr_n;
    assign wd_active = ~rst_low & ~cause & ~wdf_low & wd_en;
    assign win       = pick_window(tsel_e'(tsel), '{lo: prog_lo, hi: prog_hi},
                                   WIN_A, WIN_B);

    wdt_kick_sync i_sync (
        .clk(clk), .rst(rst), .kick(kick), .fall(fall)
    );

    wdt_hold_timer #(.LEN(TRST), .RST_VAL(1'b1)) i_rst_hold (
        .clk(clk), .rst(rst), .set(cause), .clr(1'b0), .active(rst_low)
    );

    wdt_window i_win (
        .clk(clk), .rst(rst), .active(wd_active), .fall(fall),
        .win(win), .timeout(timeout)
    );

    wdt_hold_timer #(.LEN(TRST), .RST_VAL(1'b0)) i_wdf_hold (
        .clk(clk), .rst(rst), .set(timeout), .clr(rst_low | cause),
        .active(wdf_low)
    );

    assign rst_n_o = ~rst_low;
    assign rst_oe  = rst_low;
    assign wdf_n_o = ~wdf_low;
    assign wdf_oe  = wdf_low;

    AST_CAUSE_HOLDS_RESET: assert property (@(posedge clk) disable iff (rst)
        cause |=> !rst_n_o); // R2
    AST_FAULT_ONLY_RST_HIGH: assert property (@(posedge clk) disable iff (rst)
        !rst_n_o |-> (wdf_n_o && !wdf_oe)); // R9
    AST_DISABLED_NO_FAULT: assert property (@(posedge clk) disable iff (rst)
        (!wd_en && wdf_n_o) |=> wdf_n_o); // R10
    AST_RESET_RELEASE_CLEAN: assert property (@(posedge clk) disable iff (rst)
        $rose(rst_n_o) |-> $past(!cause)); // R3
endmodule

// File: tb/test_supv_wdt.sv
module test_supv_wdt;
    localparam int CLK_P = 10;
    localparam int TRST  = 8;
    localparam int A_LO = 4, A_HI = 20, B_LO = 10, B_HI = 40;
    localparam int P_LO = 6, P_HI = 15;

    logic clk = 0, rst = 1, uv_flag = 0, mr_n = 1, wd_en = 0, kick = 1;
    logic [1:0]  tsel = 2'b01;
    logic [15:0] prog_lo = 16'(P_LO), prog_hi = 16'(P_HI);
    logic rst_n_o, rst_oe, wdf_n_o, wdf_oe;

    int total = 0, fails = 0;
    string cur_req = "R1";
    bit started = 0;

    supv_wdt #(.TRST(TRST), .A_LO(A_LO), .A_HI(A_HI), .B_LO(B_LO), .B_HI(B_HI))
    i_supv_wdt (
        .clk(clk), .rst(rst), .uv_flag(uv_flag), .mr_n(mr_n), .wd_en(wd_en),
        .kick(kick), .tsel(tsel), .prog_lo(prog_lo), .prog_hi(prog_hi),
        .rst_n_o(rst_n_o), .rst_oe(rst_oe), .wdf_n_o(wdf_n_o), .wdf_oe(wdf_oe)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(bit ok, string req, int act, int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // behavioural reference model
    int m_rlow = 1, m_rcnt = 0, m_wlow = 0, m_wcnt = 0, m_win = 0;
    int k1 = 1, k2 = 1, k3 = 1;

    always @(posedge clk) begin
        int lo, hi;
        bit fc, fall, act, tout;
        started = 1;
        fc   = uv_flag || !mr_n;
        fall = k3 && !k2;
        act  = !m_rlow && !fc && !m_wlow && wd_en;
        if (tsel == 2'b00)      begin lo = P_LO; hi = P_HI; end
        else if (tsel == 2'b01) begin lo = A_LO; hi = A_HI; end
        else                    begin lo = B_LO; hi = B_HI; end
        tout = act && ((fall && m_win < lo) || (!fall && m_win >= hi - 1));
        if (rst) begin
            m_win = 0; m_wlow = 0; m_wcnt = 0; m_rlow = 1; m_rcnt = 0;
            k1 = 1; k2 = 1; k3 = 1;
        end else begin
            if (!act || tout || fall) m_win = 0; else m_win++;
            if (m_rlow || fc) begin m_wlow = 0; m_wcnt = 0; end
            else if (tout) begin m_wlow = 1; m_wcnt = 0; end
            else if (m_wlow) begin
                if (m_wcnt == TRST - 1) begin m_wlow = 0; m_wcnt = 0; end
                else m_wcnt++;
            end
            if (fc) begin m_rlow = 1; m_rcnt = 0; end
            else if (m_rlow) begin
                if (m_rcnt == TRST - 1) begin m_rlow = 0; m_rcnt = 0; end
                else m_rcnt++;
            end
            k3 = k2; k2 = k1; k1 = kick;
        end
    end

    always @(negedge clk) begin
        if (started) begin
            chk(rst_n_o == !m_rlow, {cur_req, " rst_n_o"}, rst_n_o, !m_rlow);
            chk(wdf_n_o == !m_wlow, {cur_req, " wdf_n_o"}, wdf_n_o, !m_wlow);
            chk(rst_oe == m_rlow && wdf_oe == m_wlow, "R12 oe",
                {rst_oe, wdf_oe}, {m_rlow[0], m_wlow[0]});
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse();
        kick = 0; tick(2); kick = 1;
    endtask

    task automatic wait_wdf(int lim, output bit seen);
        seen = 0;
        for (int i = 0; i < lim && !seen; i++) begin
            @(negedge clk);
            if (!wdf_n_o) seen = 1;
        end
    endtask

    initial begin
        #(CLK_P * 150000);
        chk(0, "watchdog expired", 0, 1);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        int n;
        bit seen;
        tick(4);
        rst = 0;
        chk(rst_n_o == 0 && rst_oe == 1 && wdf_n_o == 1 && wdf_oe == 0,
            "R1 reset state", {rst_n_o, rst_oe, wdf_n_o, wdf_oe}, 4'b0110);
        // R2 / R3: undervoltage then release length
        cur_req = "R2";
        tick(12);
        uv_flag = 1; tick(1);
        chk(rst_n_o == 0, "R2 uv asserts reset", rst_n_o, 0);
        tick(3);
        cur_req = "R3";
        uv_flag = 0; n = 0;
        do begin @(negedge clk); n++; end while (!rst_n_o && n < 100);
        chk(n == TRST, "R3 hold length after uv", n, TRST);
        mr_n = 0; tick(1);
        chk(rst_n_o == 0, "R2 manual reset", rst_n_o, 0);
        mr_n = 1; n = 0;
        do begin @(negedge clk); n++; end while (!rst_n_o && n < 100);
        chk(n == TRST, "R3 hold length after mr", n, TRST);
        // R7 / R4: valid kicks with preset A
        cur_req = "R7"; tsel = 2'b01; wd_en = 1;
        tick(5); pulse();
        for (int i = 0; i < 10; i++) begin tick(8); pulse(); end
        chk(wdf_n_o == 1, "R7 periodic valid kicks", wdf_n_o, 1);
        // R6 / R8: late timeout and pulse length
        cur_req = "R6";
        wait_wdf(60, seen);
        chk(seen, "R6 missing kick faults", seen, 1);
        cur_req = "R8"; n = 1;
        while (!wdf_n_o && n < 100) begin @(negedge clk); if (!wdf_n_o) n++; end
        chk(n == TRST, "R8 fault pulse length", n, TRST);
        // R5 + R11: early kick with preset B
        cur_req = "R5"; tsel = 2'b10;
        tick(1); pulse();
        wait_wdf(8, seen);
        chk(seen, "R5 early kick faults (preset B)", seen, 1);
        tick(TRST + 2);
        // R11: programmable pair, valid cadence then early kick
        cur_req = "R11"; tsel = 2'b00;
        tick(3); pulse();
        for (int i = 0; i < 6; i++) begin tick(7); pulse(); end
        chk(wdf_n_o == 1, "R11 programmable window accepts 9-cycle cadence", wdf_n_o, 1);
        tick(1); pulse();
        wait_wdf(8, seen);
        chk(seen, "R11 programmable lower bound enforced", seen, 1);
        tick(TRST + 2);
        // R4: kick shorter path — edge acted on two edges later
        cur_req = "R4"; tsel = 2'b11;
        tick(12); pulse();
        tick(15);
        chk(wdf_n_o == 1, "R4 kick at c~14 valid for code 11", wdf_n_o, 1);
        // R10: disabled watchdog ignores kicks
        cur_req = "R10"; wd_en = 0;
        for (int i = 0; i < 20; i++) begin tick(1); pulse(); end
        tick(60);
        chk(wdf_n_o == 1, "R10 disabled no fault", wdf_n_o, 1);
        // R9: reset cause during a fault pulse
        cur_req = "R9"; wd_en = 1; tsel = 2'b01;
        wait_wdf(60, seen);
        chk(seen, "R9 setup fault", seen, 1);
        tick(2);
        mr_n = 0; tick(1);
        chk(rst_n_o == 0 && wdf_n_o == 1 && wdf_oe == 0, "R9 fault released under reset",
            {rst_n_o, wdf_n_o, wdf_oe}, 3'b010);
        tick(30);
        chk(wdf_oe == 0, "R9 no fault while reset held", wdf_oe, 0);
        mr_n = 1; tick(TRST + 5);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule